// File: doc/BRIEF.md
# Return Address Stack with Status Packing

This block holds subroutine return addresses for a small 8-bit controller core. The entries live in a 64-byte internal scratch RAM. The stack pointer is not a separate register: it is the low three bits of the program status word. The core supplies its current 12-bit program counter and status word every cycle and uses the registered values the block returns.

A push writes the return address as a two-byte entry. The upper status nibble is packed into the same byte as the high program-counter bits. Two kinds of return are offered:

- A full return restores that status nibble along with the address.
- A PC-only return brings back the address and leaves the current status nibble in place.

The same RAM stays open to the core for ordinary byte reads and writes through a separate port. When no stack strobe is active, the block registers the core's program counter and status word unchanged.

Top module: `ret_stack`

## Requirements
- R1: While rst_ni is low, pc_o and psw_o are zero and bank_base_o is 0.
- R2: A push stores two bytes, using SP = psw_i[2:0]. It writes pc_i[7:0] at RAM address 8+2*SP. At address 9+2*SP it writes a byte made of pc_i[11:8] in bits 3:0 and psw_i[7:4] in bits 7:4.
- R3: On the edge after a push, pc_o equals the pushed pc_i. psw_o equals psw_i with bits 2:0 increased by one modulo 8, so 7 wraps to 0.
- R4: Either return first lowers SP by one modulo 8, so 0 wraps to 7. It then reads the entry at that new SP. pc_o becomes {high byte bits 3:0, low byte}, and psw_o[2:0] becomes the new SP.
- R5: A full return loads psw_o[7:4] from bits 7:4 of the entry's high byte.
- R6: A PC-only return keeps psw_o[7:4] equal to psw_i[7:4].
- R7: psw_o[3] equals psw_i[3] after every push, full return and PC-only return.
- R8: bank_base_o is 24 when psw_o[4] is 1 and 0 when it is 0. After a full return it therefore follows the restored bank-select bit.
- R9: The RAM port uses only ram_addr_i[5:0]. For example, addresses 0x48, 0xC8 and 0x08 all reach the same byte. ram_rdata_o is a combinational read of that byte, and ram_we_i writes ram_wdata_i on the clock edge.
- R10: A RAM port write is dropped in any cycle where push_i, pull_full_i or pull_pc_i is high.
- R11: Only one stack operation takes place per cycle, with priority push, then full return, then PC-only return.
- R12: With no strobe active, pc_o and psw_o take pc_i and psw_i on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 12 | Current program counter from the core |
| psw_i | input | 8 | Current status word; bits 2:0 are the stack pointer |
| push_i | input | 1 | Push a return entry |
| pull_full_i | input | 1 | Return, restoring status bits 7:4 |
| pull_pc_i | input | 1 | Return, restoring the program counter only |
| ram_we_i | input | 1 | RAM port write enable |
| ram_addr_i | input | 8 | RAM port address (upper two bits ignored) |
| ram_wdata_i | input | 8 | RAM port write data |
| ram_rdata_o | output | 8 | RAM port read data |
| pc_o | output | 12 | Registered program counter |
| psw_o | output | 8 | Registered status word |
| bank_base_o | output | 5 | Register bank base offset: 0 or 24 |

## Verification
The assertions check these on every cycle:

- the stack pointer arithmetic in both directions, including wrap-around;
- the preservation of status bit 3;
- the program counter holding across a push;
- status bits 7:4 holding across a PC-only return.

The contents of the entries can only be shown by the bench's scenarios. These cover the packing of the status nibble beside the high address bits, the restored values after pushes and pops, address masking and the dropped port write. Each depends on RAM state built up over earlier cycles.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  localparam int PC_W     = 12;
  localparam int SW_W     = 8;
  localparam int SP_W     = 3;
  localparam int DW       = 8;
  localparam int AW       = 6;
  localparam int EXT_AW   = 8;
  localparam int DEPTH    = 1 << AW;
  localparam int STK_BASE = 8;
  localparam int BANK_BIT = 4;
  localparam int BANK_OFS = 24;
  localparam int BANK_W   = 5;

  typedef enum logic [1:0] {OP_NONE, OP_PUSH, OP_PULL_FULL, OP_PULL_PC} stk_op_e;
endpackage

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
  parameter int DW    = 8,
  parameter int AW    = 6,
  parameter int NRD   = 3,
  localparam int DEPTH = 1 << AW
) (
  input  logic                    clk_i,
  input  logic                    we_a_i,
  input  logic [AW-1:0]           addr_a_i,
  input  logic [DW-1:0]           wd_a_i,
  input  logic                    we_b_i,
  input  logic [AW-1:0]           addr_b_i,
  input  logic [DW-1:0]           wd_b_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_a_i) mem_q[addr_a_i] <= wd_a_i;
    if (we_b_i) mem_q[addr_b_i] <= wd_b_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/ret_stack_seq.sv
module ret_stack_seq
  import ret_stack_pkg::*;
(
  input  stk_op_e          op_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [SW_W-1:0]  psw_i,
  input  logic [DW-1:0]    lo_rd_i,
  input  logic [DW-1:0]    hi_rd_i,
  output logic [AW-1:0]    lo_addr_o,
  output logic [AW-1:0]    hi_addr_o,
  output logic [DW-1:0]    lo_wd_o,
  output logic [DW-1:0]    hi_wd_o,
  output logic [PC_W-1:0]  nxt_pc_o,
  output logic [SW_W-1:0]  nxt_psw_o
);
  logic [SP_W-1:0] sp, sp_inc, sp_dec, sp_sel;

  assign sp     = psw_i[SP_W-1:0];
  assign sp_inc = sp + 1'b1;
  assign sp_dec = sp - 1'b1;
  // pulls address the entry below the current pointer
  assign sp_sel = (op_i == OP_PUSH) ? sp : sp_dec;

  assign lo_addr_o = AW'(STK_BASE) + AW'({sp_sel, 1'b0});
  assign hi_addr_o = lo_addr_o + AW'(1);

  assign lo_wd_o = pc_i[7:0];
  assign hi_wd_o = {psw_i[7:4], pc_i[PC_W-1:8]};

  always_comb begin
    nxt_pc_o  = pc_i;
    nxt_psw_o = psw_i;
    unique case (op_i)
      OP_PUSH:      nxt_psw_o = {psw_i[7:SP_W], sp_inc};
      OP_PULL_FULL: begin
        nxt_pc_o  = {hi_rd_i[3:0], lo_rd_i};
        nxt_psw_o = {hi_rd_i[7:4], psw_i[3], sp_dec};
      end
      OP_PULL_PC: begin
        nxt_pc_o  = {hi_rd_i[3:0], lo_rd_i};
        nxt_psw_o = {psw_i[7:SP_W], sp_dec};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [SW_W-1:0]   psw_i,
  input  logic              push_i,
  input  logic              pull_full_i,
  input  logic              pull_pc_i,
  input  logic              ram_we_i,
  input  logic [EXT_AW-1:0] ram_addr_i,
  input  logic [DW-1:0]     ram_wdata_i,
  output logic [DW-1:0]     ram_rdata_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [SW_W-1:0]   psw_o,
  output logic [BANK_W-1:0] bank_base_o
);
  localparam logic [EXT_AW-1:0] EXT_MASK = EXT_AW'(DEPTH - 1);

  stk_op_e          op;
  logic             any_stk;
  logic [AW-1:0]    ext_addr, lo_addr, hi_addr;
  logic [DW-1:0]    lo_wd, hi_wd;
  logic [PC_W-1:0]  nxt_pc;
  logic [SW_W-1:0]  nxt_psw;
  logic [2:0][AW-1:0] raddr;
  logic [2:0][DW-1:0] rdata;
  logic             we_a;
  logic [AW-1:0]    addr_a;
  logic [DW-1:0]    wd_a;

  // fixed priority: push, full return, pc-only return
  always_comb begin
    if (push_i)           op = OP_PUSH;
    else if (pull_full_i) op = OP_PULL_FULL;
    else if (pull_pc_i)   op = OP_PULL_PC;
    else                  op = OP_NONE;
  end
  assign any_stk = push_i | pull_full_i | pull_pc_i;

  assign ext_addr = AW'(ram_addr_i & EXT_MASK);

  ret_stack_seq u_seq (
    .op_i      (op),
    .pc_i      (pc_i),
    .psw_i     (psw_i),
    .lo_rd_i   (rdata[0]),
    .hi_rd_i   (rdata[1]),
    .lo_addr_o (lo_addr),
    .hi_addr_o (hi_addr),
    .lo_wd_o   (lo_wd),
    .hi_wd_o   (hi_wd),
    .nxt_pc_o  (nxt_pc),
    .nxt_psw_o (nxt_psw)
  );

  // port A shared: stack low byte wins over the external write
  assign we_a   = (op == OP_PUSH) | (ram_we_i & ~any_stk);
  assign addr_a = (op == OP_PUSH) ? lo_addr : ext_addr;
  assign wd_a   = (op == OP_PUSH) ? lo_wd : ram_wdata_i;

  assign raddr[0] = lo_addr;
  assign raddr[1] = hi_addr;
  assign raddr[2] = ext_addr;

  ret_stack_mem #(.DW(DW), .AW(AW), .NRD(3)) u_mem (
    .clk_i    (clk_i),
    .we_a_i   (we_a),
    .addr_a_i (addr_a),
    .wd_a_i   (wd_a),
    .we_b_i   (op == OP_PUSH),
    .addr_b_i (hi_addr),
    .wd_b_i   (hi_wd),
    .raddr_i  (raddr),
    .rdata_o  (rdata)
  );

  assign ram_rdata_o = rdata[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o  <= '0;
      psw_o <= '0;
    end else begin
      pc_o  <= nxt_pc;
      psw_o <= nxt_psw;
    end
  end

  assign bank_base_o = psw_o[BANK_BIT] ? BANK_W'(BANK_OFS) : '0;

  p_push_sp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> psw_o[2:0] == 3'($past(psw_i[2:0]) + 3'd1));
  p_push_pc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> pc_o == $past(pc_i));
  p_pull_sp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && (pull_full_i || pull_pc_i)) |=> psw_o[2:0] == 3'($past(psw_i[2:0]) - 3'd1));
  p_pconly_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pull_full_i && pull_pc_i) |=> psw_o[7:4] == $past(psw_i[7:4]));
  p_bit3_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i || pull_full_i || pull_pc_i) |=> psw_o[3] == $past(psw_i[3]));
  p_idle_pass_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pull_full_i && !pull_pc_i) |=> (pc_o == $past(pc_i) && psw_o == $past(psw_i)));
endmodule

// File: tb/sim_ret_stack.sv
module sim_ret_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pc;
  logic [7:0]  psw;
  logic        push, pull_full, pull_pc;
  logic        ram_we;
  logic [7:0]  ram_addr, ram_wdata, ram_rdata;
  logic [11:0] pc_q;
  logic [7:0]  psw_q;
  logic [4:0]  bank;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ret_stack u0 (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .psw_i(psw),
    .push_i(push), .pull_full_i(pull_full), .pull_pc_i(pull_pc),
    .ram_we_i(ram_we), .ram_addr_i(ram_addr), .ram_wdata_i(ram_wdata),
    .ram_rdata_o(ram_rdata), .pc_o(pc_q), .psw_o(psw_q), .bank_base_o(bank)
  );

  // {push,full,pconly}, pc_i, psw_i, exp pc, exp psw, exp bank
  localparam logic [47:0] VEC [0:7] = '{
    {3'b100, 12'h123, 8'hA0, 12'h123, 8'hA1, 5'd0},   // R2 R3
    {3'b100, 12'hABC, 8'h59, 12'hABC, 8'h5A, 5'd24},  // R3 R7
    {3'b010, 12'h000, 8'h0A, 12'hABC, 8'h59, 5'd24},  // R4 R5 R7 R8
    {3'b001, 12'h000, 8'hF1, 12'h123, 8'hF0, 5'd24},  // R4 R6
    {3'b100, 12'h7FE, 8'h37, 12'h7FE, 8'h30, 5'd24},  // R3 wrap 7->0
    {3'b010, 12'h000, 8'h00, 12'h7FE, 8'h37, 5'd24},  // R4 wrap 0->7, R5
    {3'b000, 12'h555, 8'h4C, 12'h555, 8'h4C, 5'd0},   // R12
    {3'b110, 12'h0F0, 8'h4C, 12'h0F0, 8'h4D, 5'd0}    // R11 push wins
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    push = 0; pull_full = 0; pull_pc = 0; ram_we = 0;
  endtask

  initial begin
    idle();
    pc = '0; psw = '0; ram_addr = '0; ram_wdata = '0;
    #2;
    check("R1 pc", 16'(pc_q), 16'h0);
    check("R1 psw", 16'(psw_q), 16'h0);
    check("R1 bank", 16'(bank), 16'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      {push, pull_full, pull_pc} = VEC[i][47:45];
      pc  = VEC[i][44:33];
      psw = VEC[i][32:25];
      @(negedge clk);
      check($sformatf("R3/R4/R5 pc vec%0d", i), 16'(pc_q), 16'(VEC[i][24:13]));
      check($sformatf("R3/R7 psw vec%0d", i), 16'(psw_q), 16'(VEC[i][12:5]));
      check($sformatf("R8 bank vec%0d", i), 16'(bank), 16'(VEC[i][4:0]));
    end
    idle();

    // R9: masked write then aliased reads
    ram_we = 1; ram_addr = 8'h48; ram_wdata = 8'h77;
    @(negedge clk); idle();
    ram_addr = 8'h08; #1 check("R9 read 0x08", 16'(ram_rdata), 16'h77);
    ram_addr = 8'hC8; #1 check("R9 read 0xC8", 16'(ram_rdata), 16'h77);
    ram_addr = 8'h09; #1 check("R2 high byte", 16'(ram_rdata), 16'hA1);

    // R6 pc-only return reading patched low byte
    pull_pc = 1; psw = 8'h91; pc = 12'h000;
    @(negedge clk); idle();
    check("R6 pc", 16'(pc_q), 16'h177);
    check("R6 psw", 16'(psw_q), 16'h90);

    // R10: port write during push is dropped
    ram_we = 1; ram_addr = 8'h30; ram_wdata = 8'h00;
    @(negedge clk);
    push = 1; psw = 8'h02; pc = 12'h3C5; ram_wdata = 8'h11;
    @(negedge clk); idle();
    ram_addr = 8'h30; #1 check("R10 dropped write", 16'(ram_rdata), 16'h00);
    ram_addr = 8'h0C; #1 check("R2 low byte", 16'(ram_rdata), 16'hC5);
    ram_addr = 8'h0D; #1 check("R2 packed byte", 16'(ram_rdata), 16'h03);
    ram_addr = 8'h11; #1 check("R11 push entry", 16'(ram_rdata), 16'h40);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule